// File: doc/BRIEF.md
# Key-Guarded Flash Control Registers

This block is the software-facing register file of an embedded flash controller. Programming and erase commands to the flash array are locked out at reset. Software must first write two exact key words, one after the other, to a control-unlock key register. This opens the control register. A second key pair, written to a program-unlock key register, then opens program memory. A third key pair opens the write-protect register. Writing 1 to a lock bit closes that lock again.

Once the locks are open, software picks a mode in the control register and writes to the flash port. A word write programs one word. A zero word written with erase selected erases the page that holds the address. Half-page mode collects consecutive words and launches one program operation when the half-page is full. Each launch gives a one-cycle pulse to the array together with the target address. A busy counter stands in for the array timing and drives the busy and ready status flags. Protection, alignment and size errors are caught in sticky status flags.

Top module: `flash_kg_regs`

## Requirements
- R1: After reset, the control register (offset 0x04) reads 0x7 with all three locks set and all mode bits clear. The status register (0x18) reads 0x8, which is ready only. The write-protect register (0x20) reads 0.
- R2: Writing 0x89ABCDEF and then 0x02030405 to offset 0x0C clears the control lock (control bit 0). Bus writes to other offsets between the two key words do not break the sequence.
- R3: Any other value written to 0x0C returns the control-key sequence to its start. This includes a repeated first key and a second key sent without the first. The lock stays set until a fresh correct pair arrives.
- R4: Writing 0x8C9DAEBF and then 0x13141516 to offset 0x10 clears the program lock (control bit 1). Writes to 0x10 have no effect while the control lock is set.
- R5: Writing 0xFBEAD9C8 and then 0x24252627 to offset 0x14 clears the option lock (control bit 2), but only while the control lock is clear. The write-protect register holds one bit per 4 KiB sector, and it can be written only while the option lock is clear.
- R6: Writing 1 to a lock bit in the control register sets that lock. Writing 0 to a lock bit leaves it unchanged.
- R7: The mode bits are PROG (bit 3), DATA (bit 4), FTDW (bit 8), ERASE (bit 9) and FPRG (bit 10). Control-register writes update them only while the control lock is clear. While it is set, they keep their value.
- R8: A flash-port write is blocked if the program lock is set or if the write-protect bit of the target sector is set. A blocked write sets status bit 8 and starts no operation.
- R9: A flash-port write whose address has bits [1:0] not equal to zero sets status bit 9 and starts no operation.
- R10: In word mode (erase and half-page not selected), an accepted write pulses `arr_prog` for one cycle with `arr_addr` equal to the write address. Status bit 0 (busy) is then high, and bit 3 (ready) low, for exactly WORD_CYC cycles. Flash-port writes made while busy are ignored.
- R11: With PROG and ERASE both set, writing a zero word erases the page. `arr_erase` pulses with `arr_addr` set to the page base, and busy lasts ERASE_CYC cycles. Writing a non-zero word instead sets status bit 10 and starts nothing.
- R12: With PROG and FPRG set, words must arrive in ascending word order starting at the half-page base. When the last word of the half-page arrives, `arr_half` pulses with the half-page base, and busy lasts HALF_CYC cycles. A word out of order sets status bit 9 and restarts the collection.
- R13: Status bit 1 (end of operation) sets in the cycle busy falls. Status bits 1, 8, 9 and 10 stay set until software writes 1 to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| mem_we | input | 1 | Flash-port write strobe |
| mem_addr | input | ADDR_W | Flash byte address |
| mem_wdata | input | 32 | Flash write data |
| arr_prog | output | 1 | One-cycle word-program launch |
| arr_erase | output | 1 | One-cycle page-erase launch |
| arr_half | output | 1 | One-cycle half-page-program launch |
| arr_addr | output | ADDR_W | Target address of the launched operation |

## Verification
The bench targets the key-sequence corner cases: a lone second key, a repeated first key, and a wrong word between the two keys. A sequencer that only checks the last word written would unlock on these and fail R3. It also sends the program key while the control lock is set, which an ungated sequencer would accept. It writes mode bits under lock and writes zero to lock bits, expecting the control word to stay the same. It sends a flash write during busy, a non-zero erase word, an out-of-order half-page word, and a write into a protected sector. Each of these must raise only the named flag and no array pulse. Busy lengths are counted cycle by cycle, so an off-by-one in the stub counter, or an end-of-operation flag set one cycle late, shows up as a count mismatch.

// File: rtl/flash_kg_pkg.sv
package flash_kg_pkg;
  localparam logic [5:0] OFS_CTRL  = 6'h04;
  localparam logic [5:0] OFS_CKEY  = 6'h0C;
  localparam logic [5:0] OFS_PKEY  = 6'h10;
  localparam logic [5:0] OFS_OKEY  = 6'h14;
  localparam logic [5:0] OFS_STAT  = 6'h18;
  localparam logic [5:0] OFS_WPROT = 6'h20;

  localparam logic [31:0] CKEY_A = 32'h89ABCDEF;
  localparam logic [31:0] CKEY_B = 32'h02030405;
  localparam logic [31:0] PKEY_A = 32'h8C9DAEBF;
  localparam logic [31:0] PKEY_B = 32'h13141516;
  localparam logic [31:0] OKEY_A = 32'hFBEAD9C8;
  localparam logic [31:0] OKEY_B = 32'h24252627;

  typedef enum logic [1:0] {OP_WORD = 2'd0, OP_HALF = 2'd1, OP_ERASE = 2'd2} op_e;

  // erase takes priority over half-page; both need PROG
  function automatic op_e op_of(input logic prog, input logic erase, input logic fprg);
    if (prog && erase) return OP_ERASE;
    if (prog && fprg)  return OP_HALF;
    return OP_WORD;
  endfunction
endpackage

// File: rtl/flash_kg_keyseq.sv
module flash_kg_keyseq #(
  parameter logic [31:0] FIRST  = 32'h0,
  parameter logic [31:0] SECOND = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic        allow,
  input  logic [31:0] data,
  output logic        unlock
);
  logic armed;

  assign unlock = wr && allow && armed && (data == SECOND);

  // any write to the key register either arms on a fresh first key or disarms
  always_ff @(posedge clk) begin
    if (!rst_n)  armed <= 1'b0;
    else if (wr) armed <= allow && !armed && (data == FIRST);
  end
endmodule

// File: rtl/flash_kg_busy.sv
module flash_kg_busy #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CNT_W'(1)) && !start;
endmodule

// File: rtl/flash_kg_regs.sv
module flash_kg_regs
  import flash_kg_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int PAGE_BYTES   = 256,
  parameter int SECTOR_BYTES = 4096,
  parameter int WORD_CYC     = 3,
  parameter int HALF_CYC     = 6,
  parameter int ERASE_CYC    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_wdata,
  output logic              arr_prog,
  output logic              arr_erase,
  output logic              arr_half,
  output logic [ADDR_W-1:0] arr_addr
);
  localparam int HALF_BYTES = PAGE_BYTES / 2;
  localparam int HALF_WORDS = HALF_BYTES / 4;
  localparam int PAGE_LSB   = $clog2(PAGE_BYTES);
  localparam int HALF_LSB   = $clog2(HALF_BYTES);
  localparam int IDX_W      = HALF_LSB - 2;
  localparam int SECT_LSB   = $clog2(SECTOR_BYTES);
  localparam int SECT_W     = ADDR_W - SECT_LSB;
  localparam int SECTORS    = 1 << SECT_W;
  localparam int CNT_W      = $clog2(WORD_CYC + HALF_CYC + ERASE_CYC + 1);

  function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a, input int lsb);
    return (a >> lsb) << lsb;
  endfunction

  // ---- register state ----
  logic ctl_lock, pgm_lock, opt_lock;
  logic prog_b, data_b, ftdw_b, erase_b, fprg_b;
  logic [SECTORS-1:0] wprot;
  logic eop, err_wp, err_aln, err_siz;
  logic [IDX_W-1:0] hp_cnt;

  // ---- bus decode ----
  logic wr_ctrl, wr_ckey, wr_pkey, wr_okey, wr_stat, wr_wprot;
  assign wr_ctrl  = bus_we && (bus_addr == OFS_CTRL);
  assign wr_ckey  = bus_we && (bus_addr == OFS_CKEY);
  assign wr_pkey  = bus_we && (bus_addr == OFS_PKEY);
  assign wr_okey  = bus_we && (bus_addr == OFS_OKEY);
  assign wr_stat  = bus_we && (bus_addr == OFS_STAT);
  assign wr_wprot = bus_we && (bus_addr == OFS_WPROT);

  // ---- key sequencers ----
  logic ctl_unlock, pgm_unlock, opt_unlock;

  flash_kg_keyseq #(.FIRST(CKEY_A), .SECOND(CKEY_B)) u_ckey (
    .clk(clk), .rst_n(rst_n), .wr(wr_ckey), .allow(1'b1),
    .data(bus_wdata), .unlock(ctl_unlock));
  flash_kg_keyseq #(.FIRST(PKEY_A), .SECOND(PKEY_B)) u_pkey (
    .clk(clk), .rst_n(rst_n), .wr(wr_pkey), .allow(!ctl_lock),
    .data(bus_wdata), .unlock(pgm_unlock));
  flash_kg_keyseq #(.FIRST(OKEY_A), .SECOND(OKEY_B)) u_okey (
    .clk(clk), .rst_n(rst_n), .wr(wr_okey), .allow(!ctl_lock),
    .data(bus_wdata), .unlock(opt_unlock));

  // ---- flash-port command decode ----
  logic busy, busy_done;
  op_e  op;
  logic mem_go, blocked, misalign, bad_size, hp_miss, accept;
  logic start_word, start_erase, start_half, start_any;
  logic set_wp, set_aln, set_siz;
  logic [SECT_W-1:0] sector;
  logic [IDX_W-1:0]  hp_idx;
  logic [CNT_W-1:0]  run_len;

  assign op       = op_of(prog_b, erase_b, fprg_b);
  assign mem_go   = mem_we && !busy;
  assign sector   = mem_addr[ADDR_W-1:SECT_LSB];
  assign hp_idx   = mem_addr[HALF_LSB-1:2];
  assign blocked  = pgm_lock || wprot[sector];
  assign misalign = (mem_addr[1:0] != 2'b00);
  assign bad_size = (op == OP_ERASE) && (mem_wdata != 32'h0);
  assign hp_miss  = (op == OP_HALF) && (hp_idx != hp_cnt);
  assign accept   = mem_go && !blocked && !misalign && !bad_size && !hp_miss;

  assign start_word  = accept && (op == OP_WORD);
  assign start_erase = accept && (op == OP_ERASE);
  assign start_half  = accept && (op == OP_HALF) && (hp_cnt == IDX_W'(HALF_WORDS - 1));
  assign start_any   = start_word || start_erase || start_half;

  assign set_wp  = mem_go && blocked;
  assign set_aln = mem_go && !blocked && (misalign || hp_miss);
  assign set_siz = mem_go && !blocked && !misalign && bad_size;

  assign run_len = start_erase ? CNT_W'(ERASE_CYC) :
                   start_half  ? CNT_W'(HALF_CYC)  : CNT_W'(WORD_CYC);

  flash_kg_busy #(.CNT_W(CNT_W)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(start_any), .len(run_len),
    .busy(busy), .done(busy_done));

  // ---- control register and locks ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_lock <= 1'b1; pgm_lock <= 1'b1; opt_lock <= 1'b1;
      prog_b <= 1'b0; data_b <= 1'b0; ftdw_b <= 1'b0; erase_b <= 1'b0; fprg_b <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        if (bus_wdata[0]) ctl_lock <= 1'b1;
        if (bus_wdata[1]) pgm_lock <= 1'b1;
        if (bus_wdata[2]) opt_lock <= 1'b1;
        if (!ctl_lock) begin
          prog_b  <= bus_wdata[3];
          data_b  <= bus_wdata[4];
          ftdw_b  <= bus_wdata[8];
          erase_b <= bus_wdata[9];
          fprg_b  <= bus_wdata[10];
        end
      end
      if (ctl_unlock) ctl_lock <= 1'b0;
      if (pgm_unlock) pgm_lock <= 1'b0;
      if (opt_unlock) opt_lock <= 1'b0;
    end
  end

  // ---- write protect ----
  always_ff @(posedge clk) begin
    if (!rst_n)                      wprot <= '0;
    else if (wr_wprot && !opt_lock)  wprot <= bus_wdata[SECTORS-1:0];
  end

  // ---- sticky status, set wins over clear ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eop <= 1'b0; err_wp <= 1'b0; err_aln <= 1'b0; err_siz <= 1'b0;
    end else begin
      eop     <= busy_done || (eop     && !(wr_stat && bus_wdata[1]));
      err_wp  <= set_wp    || (err_wp  && !(wr_stat && bus_wdata[8]));
      err_aln <= set_aln   || (err_aln && !(wr_stat && bus_wdata[9]));
      err_siz <= set_siz   || (err_siz && !(wr_stat && bus_wdata[10]));
    end
  end

  // ---- half-page word counter ----
  always_ff @(posedge clk) begin
    if (!rst_n)                            hp_cnt <= '0;
    else if (set_aln && op == OP_HALF)     hp_cnt <= '0;
    else if (accept && op == OP_HALF)      hp_cnt <= start_half ? '0 : hp_cnt + 1'b1;
  end

  // ---- array launch outputs ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arr_prog <= 1'b0; arr_erase <= 1'b0; arr_half <= 1'b0; arr_addr <= '0;
    end else begin
      arr_prog  <= start_word;
      arr_erase <= start_erase;
      arr_half  <= start_half;
      if (start_any)
        arr_addr <= start_erase ? align_down(mem_addr, PAGE_LSB) :
                    start_half  ? align_down(mem_addr, HALF_LSB) : mem_addr;
    end
  end

  // ---- read mux ----
  logic [31:0] ctrl_word, stat_word;
  assign ctrl_word = {21'b0, fprg_b, erase_b, ftdw_b, 3'b0, data_b, prog_b,
                      opt_lock, pgm_lock, ctl_lock};
  assign stat_word = {21'b0, err_siz, err_aln, err_wp, 4'b0, !busy, 1'b0, eop, busy};

  always_comb begin
    case (bus_addr)
      OFS_CTRL:  bus_rdata = ctrl_word;
      OFS_STAT:  bus_rdata = stat_word;
      OFS_WPROT: bus_rdata = 32'(wprot);
      default:   bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/flash_kg_checker.sv
module flash_kg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [5:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        ctl_lock,
  input logic        pgm_lock,
  input logic [4:0]  mode_bits,
  input logic        busy,
  input logic        eop,
  input logic        arr_prog,
  input logic        arr_erase,
  input logic        arr_half
);
  AST_CTL_UNLOCK_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_lock) |-> $past(bus_we && bus_addr == 6'h0C && bus_wdata == 32'h02030405)); // R2

  AST_PGM_NEEDS_CTL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgm_lock) |-> $past(!ctl_lock)); // R4

  AST_MODE_FROZEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_lock |=> $stable(mode_bits)); // R7

  AST_NO_LAUNCH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_prog || arr_erase || arr_half) |-> $past(!pgm_lock)); // R8

  AST_ONE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_prog, arr_erase, arr_half})); // R10

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_prog || arr_erase || arr_half) |-> busy); // R10

  AST_EOP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> eop); // R13
endmodule

bind flash_kg_regs flash_kg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ctl_lock(ctl_lock), .pgm_lock(pgm_lock),
  .mode_bits({prog_b, data_b, ftdw_b, erase_b, fprg_b}), .busy(busy), .eop(eop),
  .arr_prog(arr_prog), .arr_erase(arr_erase), .arr_half(arr_half));

// File: tb/flash_kg_regs_test.sv
`timescale 1ns/1ps
module flash_kg_regs_test;
  localparam int WORD_CYC = 3, HALF_CYC = 6, ERASE_CYC = 10;
  localparam int PAGE = 256, HALF = 128;
  localparam logic [5:0] A_CTRL = 6'h04, A_CKEY = 6'h0C, A_PKEY = 6'h10,
                         A_OKEY = 6'h14, A_STAT = 6'h18, A_WP = 6'h20;
  localparam logic [31:0] MODE_M = 32'h0000_0718;

  logic clk = 0, rst_n = 0;
  logic bus_we = 0; logic [5:0] bus_addr = 0; logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic mem_we = 0; logic [15:0] mem_addr = 0; logic [31:0] mem_wdata = 0;
  logic arr_prog, arr_erase, arr_half; logic [15:0] arr_addr;

  int n_tests = 0, n_fail = 0;
  logic p_prog, p_erase, p_half; logic [15:0] p_addr;
  logic [31:0] rd;

  flash_kg_regs uut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .arr_prog(arr_prog), .arr_erase(arr_erase),
    .arr_half(arr_half), .arr_addr(arr_addr));

  always #10 clk = ~clk;

  function automatic logic [15:0] exp_base(input logic [15:0] a, input int size);
    return a - (a % size);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic br(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic mw(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); mem_we = 1; mem_addr = a; mem_wdata = d;
    @(posedge clk); #1;
    p_prog = arr_prog; p_erase = arr_erase; p_half = arr_half; p_addr = arr_addr;
    @(negedge clk); mem_we = 0;
  endtask

  task automatic busy_len(output int n);
    logic [31:0] s;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      br(A_STAT, s);
      if (!s[0]) break;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    logic any_early;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    br(A_CTRL, rd); chk("R1 ctrl reset", rd, 32'h7);
    br(A_STAT, rd); chk("R1 status reset", rd, 32'h8);
    br(A_WP, rd);   chk("R1 wprot reset", rd, 32'h0);

    for (int i = 0; i < 6; i++) begin
      bw(A_CTRL, $urandom & MODE_M);
      br(A_CTRL, rd); chk("R7 mode ignored while locked", rd, 32'h7);
    end
    bw(A_CTRL, 32'h0); br(A_CTRL, rd); chk("R6 zero to locks no effect", rd, 32'h7);

    bw(A_PKEY, 32'h8C9DAEBF); bw(A_PKEY, 32'h13141516);
    br(A_CTRL, rd); chk("R4 program key ignored while control locked", rd, 32'h7);

    bw(A_CKEY, 32'h02030405);
    br(A_CTRL, rd); chk("R3 lone second key", rd[0], 1);
    bw(A_CKEY, 32'h89ABCDEF); bw(A_CKEY, 32'h02030405 ^ ($urandom | 1)); bw(A_CKEY, 32'h02030405);
    br(A_CTRL, rd); chk("R3 wrong middle word", rd[0], 1);
    bw(A_CKEY, 32'h89ABCDEF); bw(A_CKEY, 32'h89ABCDEF); bw(A_CKEY, 32'h02030405);
    br(A_CTRL, rd); chk("R3 repeated first key", rd[0], 1);

    bw(A_CKEY, 32'h89ABCDEF); bw(A_STAT, 32'h0); bw(A_CKEY, 32'h02030405);
    br(A_CTRL, rd); chk("R2 control unlock", rd, 32'h6);

    bw(A_CTRL, 32'h8); br(A_CTRL, rd); chk("R7 mode write when open", rd, 32'hE);

    mw(16'h0100, 32'h5);
    chk("R8 no launch while program locked", {p_prog, p_erase, p_half}, 3'b000);
    br(A_STAT, rd); chk("R8 write-protect error", rd, 32'h108);
    bw(A_STAT, 32'h100); br(A_STAT, rd); chk("R13 clear by writing 1", rd, 32'h8);

    bw(A_PKEY, 32'h8C9DAEBF); bw(A_PKEY, 32'h13141516);
    br(A_CTRL, rd); chk("R4 program unlock", rd, 32'hC);

    mw(16'h0102, 32'h1);
    chk("R9 no launch misaligned", {p_prog, p_erase, p_half}, 3'b000);
    br(A_STAT, rd); chk("R9 alignment error", rd, 32'h208);
    bw(A_STAT, 32'h200);

    for (int i = 0; i < 4; i++) begin
      logic [15:0] a;
      a = 16'($urandom) & 16'hFFFC;
      mw(a, $urandom);
      chk("R10 word launch", {p_prog, p_erase, p_half}, 3'b100);
      chk("R10 word address", p_addr, a);
      busy_len(n); chk("R10 busy length", n, WORD_CYC);
      br(A_STAT, rd); chk("R13 end of operation", rd, 32'hA);
      bw(A_STAT, 32'h2); br(A_STAT, rd); chk("R13 eop cleared", rd, 32'h8);
    end
    mw(16'h0400, 32'h1);
    mw(16'h0404, 32'h2);
    chk("R10 write while busy ignored", {p_prog, p_erase, p_half}, 3'b000);
    busy_len(n);
    br(A_STAT, rd); chk("R10 no error after busy write", rd, 32'hA);
    bw(A_STAT, 32'h2);

    bw(A_WP, 32'h8); br(A_WP, rd); chk("R5 wprot locked", rd, 32'h0);
    bw(A_OKEY, 32'hFBEAD9C8); bw(A_OKEY, 32'h24252627);
    br(A_CTRL, rd); chk("R5 option unlock", rd, 32'h8);
    bw(A_WP, 32'h8); br(A_WP, rd); chk("R5 wprot written", rd, 32'h8);
    mw(16'h3010, 32'h1);
    chk("R8 protected sector no launch", p_prog, 0);
    br(A_STAT, rd); chk("R8 protected sector error", rd, 32'h108);
    bw(A_STAT, 32'h100);
    mw(16'h2010, 32'h1);
    chk("R8 open sector launches", p_prog, 1);
    busy_len(n); bw(A_STAT, 32'h2);

    bw(A_CTRL, 32'h208);
    mw(16'h1234, 32'h7);
    chk("R11 nonzero erase no launch", {p_prog, p_erase, p_half}, 3'b000);
    br(A_STAT, rd); chk("R11 size error", rd, 32'h408);
    bw(A_STAT, 32'h400);
    mw(16'h1234, 32'h0);
    chk("R11 erase launch", {p_prog, p_erase, p_half}, 3'b010);
    chk("R11 page base", p_addr, exp_base(16'h1234, PAGE));
    busy_len(n); chk("R11 erase busy", n, ERASE_CYC);
    bw(A_STAT, 32'h2);

    bw(A_CTRL, 32'h408);
    any_early = 0;
    for (int i = 0; i < HALF / 4; i++) begin
      mw(16'h2080 + 16'(i * 4), 32'(i));
      if (i < HALF / 4 - 1) any_early |= p_prog | p_erase | p_half;
    end
    chk("R12 no early launch", any_early, 0);
    chk("R12 half launch", {p_prog, p_erase, p_half}, 3'b001);
    chk("R12 half base", p_addr, exp_base(16'h20FC, HALF));
    busy_len(n); chk("R12 half busy", n, HALF_CYC);
    bw(A_STAT, 32'h2);
    mw(16'h2080, 32'h0); mw(16'h2088, 32'h0);
    chk("R12 out of order no launch", p_half, 0);
    br(A_STAT, rd); chk("R12 out of order error", rd, 32'h208);
    bw(A_STAT, 32'h200);
    for (int i = 0; i < HALF / 4; i++) mw(16'h2080 + 16'(i * 4), 32'h0);
    chk("R12 restart completes", p_half, 1);
    busy_len(n); bw(A_STAT, 32'h2);

    bw(A_CTRL, 32'h40A); bw(A_CTRL, 32'h409);
    br(A_CTRL, rd); chk("R6 relock", rd, 32'h40B);
    bw(A_CTRL, 32'h1); br(A_CTRL, rd); chk("R7 mode kept after relock", rd, 32'h40B);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule